// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between a host write port and a flash operation sequencer. It watches each host write, given as an address, a data byte and a one-cycle write strobe, and turns valid command sequences into operation requests. No command is taken unless it is preceded by a fixed pair of key writes. Short commands need one more write after the keys. Erase and protection commands also need a setup code, a second key pair and a final write.

For each accepted command the block raises a one-cycle request with an operation code and, for sector commands, the sector number taken from the top address bits of the final write. It also keeps a read-path select that tells the data path whether host reads return array data, identifier data or status. The sequencer reports whether it is programming, erasing or holding a suspended erase. The decoder uses these inputs to drop commands that are not allowed in that state. A dropped command raises no request and leaves the read-path select as it was.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: The key pair is data 0xAA at address 0x5555, then data 0x55 at address 0x2AAA. Only address bits [14:0] are compared, so the upper address bits have no effect.
- R2: After the key pair, a third write at 0x5555 requests an operation, with `req_op` encoded as follows: 0xF0 read array = 1, 0x90 read ID = 2, 0xA0 program = 3, 0xB0 suspend = 4, 0xD0 resume = 5, 0x70 read status = 6, 0x50 clear status = 7, 0xE0 abort = 8.
- R3: An erase needs six writes: keys, 0x80 at 0x5555, keys, then a final write. A final 0x10 at 0x5555 requests chip erase (op 9, sector 0). A final 0x30 at any address requests sector erase (op 10). The sector number is address bits [20:16] of the final write.
- R4: Protection needs six writes: keys, 0x60 at 0x5555, keys, then a final 0x20 (protect, op 11) or 0x40 (unprotect, op 12). The final write must address sector 0 or sector 31. Any other sector gives no request.
- R5: `req_valid` is high for exactly one clock, in the cycle after the clock edge that samples the final write. `req_op` and `req_sector` are valid with it, and `req_sector` is 0 for commands without a sector.
- R6: `rd_sel` encoding is 0 = array, 1 = ID, 2 = status, and it resets to 0. An accepted read array sets 0 and an accepted read ID sets 1. An accepted read status, program, suspend, either erase, protect or unprotect sets 2. All other commands and every rejected write leave it unchanged.
- R7: A write that does not match the next expected step returns the decoder to idle with no request. The following sequence must start again with the first key write.
- R8: While `busy_prog` is high and `suspended` is low, only read status is accepted.
- R9: While `busy_erase` is high and neither `suspended` nor `busy_prog` is high, only read status and suspend are accepted.
- R10: While `suspended` is high, whatever the other busy inputs, only read array, read status, abort and resume are accepted.
- R11: With no busy or suspend input high, every command except suspend and resume is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 21 | Host write address |
| wr_data | input | 8 | Host write data / command code |
| busy_prog | input | 1 | Sequencer is running a program operation |
| busy_erase | input | 1 | Sequencer is running an erase |
| suspended | input | 1 | Erase is held in the suspended state |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 4 | Requested operation code |
| req_sector | output | 5 | Sector number for sector commands |
| rd_sel | output | 2 | Read-path select |

## Verification
The bench puts high bits on the key addresses. A decoder that compares the full address would then never unlock. It breaks sequences at each step and then sends the rest of a valid sequence. A decoder that resynchronises on a stray key write would then issue a request that should not exist. Protection of a middle sector, and a chip-erase code at a non-command address, must both be dropped. A decoder that skips those checks would issue a request for them. The bench tries each busy mode with the commands that must pass and the commands that must be dropped. It raises `suspended` together with `busy_prog` to show which input takes priority. After every command it reads `rd_sel`, so a rejected command that still moves the read path is caught.

// File: rtl/cud_pkg.sv
package cud_pkg;

  typedef enum logic [3:0] {
    OP_NONE         = 4'd0,
    OP_READ_ARRAY   = 4'd1,
    OP_READ_ID      = 4'd2,
    OP_PROGRAM      = 4'd3,
    OP_SUSPEND      = 4'd4,
    OP_RESUME       = 4'd5,
    OP_READ_STATUS  = 4'd6,
    OP_CLEAR_STATUS = 4'd7,
    OP_ABORT        = 4'd8,
    OP_CHIP_ERASE   = 4'd9,
    OP_SECTOR_ERASE = 4'd10,
    OP_PROTECT      = 4'd11,
    OP_UNPROTECT    = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_ID     = 2'd1,
    RD_STATUS = 2'd2
  } rdsel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_SETUP,
    ST_XKEY1,
    ST_XKEY2
  } seq_st_e;

  localparam logic [31:0] KEY1_ADDR = 32'h0000_5555;
  localparam logic [31:0] KEY2_ADDR = 32'h0000_2AAA;
  localparam logic [7:0]  KEY1_DATA = 8'hAA;
  localparam logic [7:0]  KEY2_DATA = 8'h55;

  localparam logic [7:0] CODE_READ_ARRAY   = 8'hF0;
  localparam logic [7:0] CODE_READ_ID      = 8'h90;
  localparam logic [7:0] CODE_PROGRAM      = 8'hA0;
  localparam logic [7:0] CODE_SUSPEND      = 8'hB0;
  localparam logic [7:0] CODE_RESUME       = 8'hD0;
  localparam logic [7:0] CODE_READ_STATUS  = 8'h70;
  localparam logic [7:0] CODE_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] CODE_ABORT        = 8'hE0;
  localparam logic [7:0] CODE_SETUP_ERASE  = 8'h80;
  localparam logic [7:0] CODE_SETUP_PROT   = 8'h60;
  localparam logic [7:0] CODE_CHIP_ERASE   = 8'h10;
  localparam logic [7:0] CODE_SECTOR_ERASE = 8'h30;
  localparam logic [7:0] CODE_PROTECT      = 8'h20;
  localparam logic [7:0] CODE_UNPROTECT    = 8'h40;

endpackage

// File: rtl/cud_match.sv
module cud_match
  import cud_pkg::*;
#(
  parameter int MATCH_W = 15,
  parameter int DATA_W  = 8
) (
  input  logic [MATCH_W-1:0] addr_lo,
  input  logic [DATA_W-1:0]  data,
  output logic               key1_hit,
  output logic               key2_hit,
  output logic               at_cmd_addr,
  output op_e                short_op,
  output logic               setup_erase,
  output logic               setup_prot
);

  logic at_key2_addr;

  assign at_cmd_addr  = (addr_lo == KEY1_ADDR[MATCH_W-1:0]);
  assign at_key2_addr = (addr_lo == KEY2_ADDR[MATCH_W-1:0]);

  assign key1_hit    = at_cmd_addr  && (data == KEY1_DATA[DATA_W-1:0]);
  assign key2_hit    = at_key2_addr && (data == KEY2_DATA[DATA_W-1:0]);
  assign setup_erase = at_cmd_addr  && (data == CODE_SETUP_ERASE[DATA_W-1:0]);
  assign setup_prot  = at_cmd_addr  && (data == CODE_SETUP_PROT[DATA_W-1:0]);

  always_comb begin
    short_op = OP_NONE;
    if (at_cmd_addr) begin
      case (data)
        CODE_READ_ARRAY[DATA_W-1:0]:   short_op = OP_READ_ARRAY;
        CODE_READ_ID[DATA_W-1:0]:      short_op = OP_READ_ID;
        CODE_PROGRAM[DATA_W-1:0]:      short_op = OP_PROGRAM;
        CODE_SUSPEND[DATA_W-1:0]:      short_op = OP_SUSPEND;
        CODE_RESUME[DATA_W-1:0]:       short_op = OP_RESUME;
        CODE_READ_STATUS[DATA_W-1:0]:  short_op = OP_READ_STATUS;
        CODE_CLEAR_STATUS[DATA_W-1:0]: short_op = OP_CLEAR_STATUS;
        CODE_ABORT[DATA_W-1:0]:        short_op = OP_ABORT;
        default:                       short_op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cud_seq.sv
module cud_seq
  import cud_pkg::*;
#(
  parameter int SECT_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] data,
  input  logic [SECT_W-1:0] sector_in,
  input  logic              key1_hit,
  input  logic              key2_hit,
  input  logic              at_cmd_addr,
  input  op_e               short_op,
  input  logic              setup_erase,
  input  logic              setup_prot,
  output logic              cand_valid,
  output op_e               cand_op,
  output logic [SECT_W-1:0] cand_sector
);

  localparam logic [SECT_W-1:0] SECT_FIRST = '0;
  localparam logic [SECT_W-1:0] SECT_LAST  = '1;

  seq_st_e st_q, st_d;
  logic    kind_prot_q, kind_prot_d;
  logic    edge_sector;

  assign edge_sector = (sector_in == SECT_FIRST) || (sector_in == SECT_LAST);

  always_comb begin
    st_d        = st_q;
    kind_prot_d = kind_prot_q;
    cand_valid  = 1'b0;
    cand_op     = OP_NONE;
    cand_sector = '0;
    if (wr_en) begin
      st_d = ST_IDLE;
      case (st_q)
        ST_IDLE:  if (key1_hit) st_d = ST_KEY1;
        ST_KEY1:  if (key2_hit) st_d = ST_KEY2;
        ST_KEY2: begin
          if (short_op != OP_NONE) begin
            cand_valid = 1'b1;
            cand_op    = short_op;
          end else if (setup_erase) begin
            st_d        = ST_SETUP;
            kind_prot_d = 1'b0;
          end else if (setup_prot) begin
            st_d        = ST_SETUP;
            kind_prot_d = 1'b1;
          end
        end
        ST_SETUP: if (key1_hit) st_d = ST_XKEY1;
        ST_XKEY1: if (key2_hit) st_d = ST_XKEY2;
        ST_XKEY2: begin
          if (!kind_prot_q) begin
            if (at_cmd_addr && data == CODE_CHIP_ERASE[DATA_W-1:0]) begin
              cand_valid = 1'b1;
              cand_op    = OP_CHIP_ERASE;
            end else if (data == CODE_SECTOR_ERASE[DATA_W-1:0]) begin
              cand_valid  = 1'b1;
              cand_op     = OP_SECTOR_ERASE;
              cand_sector = sector_in;
            end
          end else if (edge_sector) begin
            if (data == CODE_PROTECT[DATA_W-1:0]) begin
              cand_valid  = 1'b1;
              cand_op     = OP_PROTECT;
              cand_sector = sector_in;
            end else if (data == CODE_UNPROTECT[DATA_W-1:0]) begin
              cand_valid  = 1'b1;
              cand_op     = OP_UNPROTECT;
              cand_sector = sector_in;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      kind_prot_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      kind_prot_q <= kind_prot_d;
    end
  end

endmodule

// File: rtl/cud_filter.sv
module cud_filter
  import cud_pkg::*;
(
  input  logic cand_valid,
  input  op_e  cand_op,
  input  logic busy_prog,
  input  logic busy_erase,
  input  logic suspended,
  output logic accept
);

  logic allow;

  always_comb begin
    if (suspended)
      allow = (cand_op == OP_READ_ARRAY) || (cand_op == OP_READ_STATUS) ||
              (cand_op == OP_ABORT)      || (cand_op == OP_RESUME);
    else if (busy_prog)
      allow = (cand_op == OP_READ_STATUS);
    else if (busy_erase)
      allow = (cand_op == OP_READ_STATUS) || (cand_op == OP_SUSPEND);
    else
      allow = (cand_op != OP_SUSPEND) && (cand_op != OP_RESUME);
  end

  assign accept = cand_valid && allow;

endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder
  import cud_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 8,
  parameter int SECT_W  = 5,
  parameter int MATCH_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_prog,
  input  logic              busy_erase,
  input  logic              suspended,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [SECT_W-1:0] req_sector,
  output logic [1:0]        rd_sel
);

  localparam int SECT_LSB = ADDR_W - SECT_W;
  localparam int GAP_W    = SECT_LSB - MATCH_W;

  logic              key1_hit, key2_hit, at_cmd_addr, setup_erase, setup_prot;
  op_e               short_op;
  logic              cand_valid, accept;
  op_e               cand_op;
  logic [SECT_W-1:0] cand_sector;
  rdsel_e            rd_q, rd_d;

  generate
    if (GAP_W > 0) begin : g_gap
      logic addr_gap_unused;
      assign addr_gap_unused = ^wr_addr[SECT_LSB-1:MATCH_W];
    end
  endgenerate

  cud_match #(.MATCH_W(MATCH_W), .DATA_W(DATA_W)) u_match (
    .addr_lo     (wr_addr[MATCH_W-1:0]),
    .data        (wr_data),
    .key1_hit    (key1_hit),
    .key2_hit    (key2_hit),
    .at_cmd_addr (at_cmd_addr),
    .short_op    (short_op),
    .setup_erase (setup_erase),
    .setup_prot  (setup_prot)
  );

  cud_seq #(.SECT_W(SECT_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .data        (wr_data),
    .sector_in   (wr_addr[ADDR_W-1:SECT_LSB]),
    .key1_hit    (key1_hit),
    .key2_hit    (key2_hit),
    .at_cmd_addr (at_cmd_addr),
    .short_op    (short_op),
    .setup_erase (setup_erase),
    .setup_prot  (setup_prot),
    .cand_valid  (cand_valid),
    .cand_op     (cand_op),
    .cand_sector (cand_sector)
  );

  cud_filter u_filter (
    .cand_valid (cand_valid),
    .cand_op    (cand_op),
    .busy_prog  (busy_prog),
    .busy_erase (busy_erase),
    .suspended  (suspended),
    .accept     (accept)
  );

  always_comb begin
    rd_d = rd_q;
    if (accept) begin
      case (cand_op)
        OP_READ_ARRAY: rd_d = RD_ARRAY;
        OP_READ_ID:    rd_d = RD_ID;
        OP_READ_STATUS, OP_PROGRAM, OP_SUSPEND, OP_CHIP_ERASE,
        OP_SECTOR_ERASE, OP_PROTECT, OP_UNPROTECT: rd_d = RD_STATUS;
        default:       rd_d = rd_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_op     <= OP_NONE;
      req_sector <= '0;
      rd_q       <= RD_ARRAY;
    end else begin
      req_valid  <= accept;
      req_op     <= accept ? cand_op : OP_NONE;
      req_sector <= accept ? cand_sector : '0;
      rd_q       <= rd_d;
    end
  end

  assign rd_sel = rd_q;

endmodule

// File: rtl/cud_checker.sv
module cud_checker
  import cud_pkg::*;
#(
  parameter int SECT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              busy_prog,
  input logic              busy_erase,
  input logic              suspended,
  input logic              req_valid,
  input logic [3:0]        req_op,
  input logic [SECT_W-1:0] req_sector,
  input logic [1:0]        rd_sel
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R5

  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(wr_en)); // R5

  AST_PROT_EDGE_SECTOR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == OP_PROTECT || req_op == OP_UNPROTECT))
      |-> (req_sector == '0 || req_sector == '1)); // R4

  AST_RDSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> $stable(rd_sel)); // R6

  AST_PROG_ONLY_STATUS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(busy_prog) && !$past(suspended))
      |-> req_op == OP_READ_STATUS); // R8

  AST_SUSPEND_NEEDS_ERASE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_SUSPEND)
      |-> ($past(busy_erase) && !$past(suspended) && !$past(busy_prog))); // R9

  AST_SUSPENDED_SET: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(suspended))
      |-> (req_op == OP_READ_ARRAY || req_op == OP_READ_STATUS ||
           req_op == OP_ABORT || req_op == OP_RESUME)); // R10

endmodule

bind cmd_unlock_decoder cud_checker #(.SECT_W(SECT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .busy_prog  (busy_prog),
  .busy_erase (busy_erase),
  .suspended  (suspended),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_sector (req_sector),
  .rd_sel     (rd_sel)
);

// File: tb/sim_cmd_unlock_decoder.sv
`timescale 1ns/1ps
module sim_cmd_unlock_decoder;

  localparam logic [20:0] A1 = 21'h005555;
  localparam logic [20:0] A2 = 21'h002AAA;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [20:0] wr_addr;
  logic [7:0]  wr_data;
  logic        busy_prog, busy_erase, suspended;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [4:0]  req_sector;
  logic [1:0]  rd_sel;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;
  logic       got_v;
  logic [3:0] got_op;
  logic [4:0] got_sec;
  logic [1:0] got_rd;

  always #5 clk = ~clk;

  cmd_unlock_decoder u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_prog(busy_prog), .busy_erase(busy_erase), .suspended(suspended),
    .req_valid(req_valid), .req_op(req_op), .req_sector(req_sector), .rd_sel(rd_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    got_v = req_valid; got_op = req_op; got_sec = req_sector; got_rd = rd_sel;
  endtask

  task automatic expect_req(input string tag, input bit v, input int op, input int sec, input int rd);
    check({tag, " valid"}, int'(got_v), int'(v));
    if (v) begin
      check({tag, " op"}, int'(got_op), op);
      check({tag, " sector"}, int'(got_sec), sec);
    end
    check({tag, " rd_sel"}, int'(got_rd), rd);
    @(negedge clk);
    check({tag, " R5 pulse ends"}, int'(req_valid), 0);
  endtask

  task automatic cmd3(input logic [7:0] code, input bit v, input int op, input int rd, input string tag);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, code);
    expect_req(tag, v, op, 0, rd);
  endtask

  task automatic cmd6(input logic [7:0] setup, input logic [20:0] fa, input logic [7:0] fc,
                      input bit v, input int op, input int sec, input int rd, input string tag);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, setup);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(fa, fc);
    expect_req(tag, v, op, sec, rd);
  endtask

  task automatic t_reset;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    busy_prog = 1'b0; busy_erase = 1'b0; suspended = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset rd_sel array", int'(rd_sel), 0);
    check("R5 reset req_valid", int'(req_valid), 0);
  endtask

  task automatic t_upper_bits;
    wr({6'h2B, 15'h5555}, 8'hAA); wr({6'h3F, 15'h2AAA}, 8'h55); wr({6'h11, 15'h5555}, 8'h70);
    expect_req("R1 upper bits ignored", 1, 6, 0, 2);
  endtask

  task automatic t_short_codes;
    cmd3(8'hF0, 1, 1, 0, "R2 read array");
    cmd3(8'h90, 1, 2, 1, "R2 read id");
    cmd3(8'hA0, 1, 3, 2, "R2 program");
    cmd3(8'h50, 1, 7, 2, "R2 clear status");
    cmd3(8'hE0, 1, 8, 2, "R2 abort");
    cmd3(8'hF0, 1, 1, 0, "R6 back to array");
    cmd3(8'h50, 1, 7, 0, "R6 clear keeps rd_sel");
    cmd3(8'hB0, 0, 0, 0, "R11 suspend idle dropped");
    cmd3(8'hD0, 0, 0, 0, "R11 resume idle dropped");
    cmd3(8'h33, 0, 0, 0, "R7 unknown code");
  endtask

  task automatic t_erase;
    cmd6(8'h80, A1, 8'h10, 1, 9, 0, 2, "R3 chip erase");
    cmd3(8'hF0, 1, 1, 0, "R6 read array");
    cmd6(8'h80, {5'd13, 16'h0123}, 8'h30, 1, 10, 13, 2, "R3 sector erase");
    cmd3(8'hF0, 1, 1, 0, "R6 read array");
    cmd6(8'h80, 21'h001234, 8'h10, 0, 0, 0, 0, "R3 chip code off address");
  endtask

  task automatic t_protect;
    cmd6(8'h60, {5'd31, 16'h0000}, 8'h20, 1, 11, 31, 2, "R4 protect top");
    cmd3(8'hF0, 1, 1, 0, "R6 read array");
    cmd6(8'h60, {5'd0, 16'h0040}, 8'h40, 1, 12, 0, 2, "R4 unprotect bottom");
    cmd3(8'hF0, 1, 1, 0, "R6 read array");
    cmd6(8'h60, {5'd5, 16'h0000}, 8'h20, 0, 0, 0, 0, "R4 middle sector dropped");
  endtask

  task automatic t_broken;
    wr(A1, 8'hAA); wr(A2, 8'h54); wr(A2, 8'h55); wr(A1, 8'hF0);
    expect_req("R7 bad key2 then tail", 0, 0, 0, 0);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h33); wr(A2, 8'h55); wr(A1, 8'h90);
    expect_req("R7 bad code then tail", 0, 0, 0, 0);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h80); wr(A1, 8'hAA); wr(A1, 8'h55);
    wr(A1, 8'h10);
    expect_req("R7 bad second key", 0, 0, 0, 0);
    cmd3(8'h90, 1, 2, 1, "R7 recovery");
  endtask

  task automatic t_busy_prog;
    cmd3(8'hF0, 1, 1, 0, "R11 read array");
    busy_prog = 1'b1;
    cmd3(8'h90, 0, 0, 0, "R8 id dropped");
    cmd3(8'hF0, 0, 0, 0, "R8 read array dropped");
    cmd6(8'h80, A1, 8'h10, 0, 0, 0, 0, "R8 chip erase dropped");
    cmd3(8'h70, 1, 6, 2, "R8 status accepted");
    busy_prog = 1'b0;
  endtask

  task automatic t_busy_erase;
    cmd3(8'h90, 1, 2, 1, "R11 read id");
    busy_erase = 1'b1;
    cmd3(8'hF0, 0, 0, 1, "R9 read array dropped");
    cmd3(8'h50, 0, 0, 1, "R9 clear dropped");
    cmd3(8'hB0, 1, 4, 2, "R9 suspend accepted");
    cmd3(8'h70, 1, 6, 2, "R9 status accepted");
  endtask

  task automatic t_suspended;
    suspended = 1'b1;
    cmd3(8'hF0, 1, 1, 0, "R10 read array accepted");
    cmd3(8'h50, 0, 0, 0, "R10 clear dropped");
    cmd3(8'hB0, 0, 0, 0, "R10 suspend dropped");
    cmd3(8'hE0, 1, 8, 0, "R10 abort accepted");
    cmd3(8'hD0, 1, 5, 0, "R10 resume accepted");
    busy_prog = 1'b1;
    cmd3(8'hF0, 1, 1, 0, "R10 precedence over prog");
    busy_prog = 1'b0; busy_erase = 1'b0; suspended = 1'b0;
  endtask

  initial begin
    t_reset;
    t_upper_bits;
    t_short_codes;
    t_erase;
    t_protect;
    t_broken;
    t_busy_prog;
    t_busy_erase;
    t_suspended;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R5: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule